// File: doc/BRIEF.md
# Global-Shutter Frame Timing Sequencer

This controller generates the per-frame pixel-array control pulses for a global-shutter image sensor. A frame begins with a photodiode reset pulse. An integration interval follows, with an optional second reset pulse for double-slope exposure. Next comes the transfer window. There the active-low memory-boost line drops and encloses a precharge pulse and a sample pulse, which move the photodiode charge into the in-pixel memory. Once the boost line returns high, the array is read out line by line. Each line opens with a one-cycle line sync, followed by one pixel strobe per column.

All widths and delays are given in system-clock cycles on the configuration inputs. The controller checks them when a trigger arrives and latches them only if they obey the ordering rules. If any rule is broken, the controller raises the configuration error flag and does not start the frame. The next frame may be triggered while the current frame is being read out, so its reset and integration run alongside that readout. Its transfer window is held back until the current readout has finished.

Top module: `gs_frame_seq`

## Requirements
- R1: While reset is held and right after it is released, `boost_n` is 1 and `pchg`, `smpl`, `pd_rst`, `ds_rst`, `line_sync`, `pix_stb`, `done`, `busy` and `cfg_err` are all 0.
- R2: During a transfer window, `boost_n` (0 = active) stays low for exactly `ovh_len` cycles, and `pchg` and `smpl` are only ever high while `boost_n` is low.
- R3: `pchg` rises `pre_dly` cycles after `boost_n` falls and stays high for `pre_len` cycles. `smpl` rises `smp_dly` cycles after `boost_n` falls and stays high for `smp_len` cycles.
- R4: A trigger whose configuration breaks a rule sets `cfg_err` and starts nothing. When the block is idle, `busy` stays 0 and no reset or boost pulse appears. The rules are:
  - `ovh_len` lies within [OVH_MIN, OVH_MAX], `pre_len` within [PRE_MIN, PRE_MAX] and `smp_len` within [SMP_MIN, SMP_MAX].
  - `pre_dly+pre_len` ≤ `ovh_len` and `smp_dly+smp_len` ≤ `ovh_len`.
  - `ovh_len-smp_dly` > GAP_MIN.
  - The overlap of `pchg` and `smpl` is more than OVL_MIN cycles.
  - The effective integration is greater than `smp_dly`.
  - `rst_len` ≥ 1.
  - When `ds_en`=1, `ds_len` ≥ DS_MIN and `ds_dly+ds_len` ≤ effective integration − `smp_dly`.
- R5: The effective integration is max(`int_len`, INT_MIN). It equals the number of cycles from the first cycle after `pd_rst` falls to the rise of `smpl`, whenever the transfer does not have to wait for a readout.
- R6: `pd_rst` rises in the cycle after an accepted trigger and stays high for `rst_len` cycles. It is never high while `boost_n` is low.
- R7: With `ds_en`=1, `ds_rst` rises `ds_dly` cycles after `pd_rst` falls and stays high for `ds_len` cycles. With `ds_en`=0 it stays low.
- R8: Readout starts in the cycle in which `boost_n` rises. Each of the ROWS lines is one `line_sync` cycle followed by COLS `pix_stb` cycles. `row_idx` counts 0..ROWS-1 and `col_idx` counts 0..COLS-1 on the strobes.
- R9: `done` is high for a single cycle, ROWS*(COLS+1) cycles after `boost_n` rises. `busy` is high from the cycle after the trigger through the `done` cycle and falls after it when no other frame is pending.
- R10: A trigger that arrives during readout is accepted. Its reset pulse runs during that readout, and its transfer window starts only after the current frame's `done`.
- R11: A trigger is ignored while a transfer window is in progress or while the previous trigger's reset, integration or pending transfer is still under way.
- R12: Every trigger that is evaluated updates `cfg_err`, so a valid configuration clears an earlier error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Frame start request |
| ovh_len | input | CW | Transfer window length (boost low), cycles |
| pre_dly | input | CW | Precharge start offset into the window |
| pre_len | input | CW | Precharge width |
| smp_dly | input | CW | Sample start offset into the window |
| smp_len | input | CW | Sample width |
| int_len | input | CW | Requested integration length |
| rst_len | input | CW | Photodiode reset pulse width |
| ds_en | input | 1 | Double-slope reset enable |
| ds_dly | input | CW | Double-slope pulse offset after reset fall |
| ds_len | input | CW | Double-slope pulse width |
| boost_n | output | 1 | Memory-boost line, low during transfer |
| pchg | output | 1 | Precharge pulse |
| smpl | output | 1 | Sample pulse |
| pd_rst | output | 1 | Photodiode reset pulse |
| ds_rst | output | 1 | Double-slope reset pulse |
| line_sync | output | 1 | Line start strobe |
| pix_stb | output | 1 | Pixel clock strobe, one per column |
| row_idx | output | RW | Current line index |
| col_idx | output | KW | Current column index on a strobe |
| done | output | 1 | One-cycle end-of-frame strobe |
| busy | output | 1 | A frame is in progress |
| cfg_err | output | 1 | Last evaluated configuration was rejected |

## Verification
The assertions assume that the configuration inputs are stable during the trigger cycle, and that `trig` is sampled only at clock edges. They also assume that the clock-count limits are set so that a valid transfer window is never longer than a counter can hold. The bench changes configuration only one cycle ahead of a trigger. Its random draws range somewhat outside every legal window, so rejected configurations are also exercised. Directed cases then test each ordering rule at its exact boundary, a trigger during readout, and triggers that must be ignored.

// File: rtl/gs_frame_seq.sv
module gs_frame_seq #(
  parameter int CW      = 16,
  parameter int ROWS    = 2048,
  parameter int COLS    = 2048,
  parameter int OVH_MIN = 625,
  parameter int OVH_MAX = 1025,
  parameter int PRE_MIN = 375,
  parameter int PRE_MAX = 750,
  parameter int SMP_MIN = 625,
  parameter int SMP_MAX = 1000,
  parameter int OVL_MIN = 250,
  parameter int GAP_MIN = 25,
  parameter int INT_MIN = 125,
  parameter int DS_MIN  = 250,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int KW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [CW-1:0] ovh_len,
  input  logic [CW-1:0] pre_dly,
  input  logic [CW-1:0] pre_len,
  input  logic [CW-1:0] smp_dly,
  input  logic [CW-1:0] smp_len,
  input  logic [CW-1:0] int_len,
  input  logic [CW-1:0] rst_len,
  input  logic          ds_en,
  input  logic [CW-1:0] ds_dly,
  input  logic [CW-1:0] ds_len,
  output logic          boost_n,
  output logic          pchg,
  output logic          smpl,
  output logic          pd_rst,
  output logic          ds_rst,
  output logic          line_sync,
  output logic          pix_stb,
  output logic [RW-1:0] row_idx,
  output logic [KW-1:0] col_idx,
  output logic          done,
  output logic          busy,
  output logic          cfg_err
);
  localparam int XW = CW + 2;

  typedef enum logic [1:0] {EX_IDLE, EX_RST, EX_INT, EX_WAIT} ex_t;
  typedef enum logic [1:0] {XF_IDLE, XF_XFER, XF_READ, XF_DONE} xf_t;

  ex_t ex_st;
  xf_t xf_st;
  logic [XW-1:0] ex_cnt, r_wait;
  logic [CW-1:0] xf_cnt;
  logic [RW-1:0] row;
  logic [KW-1:0] col;
  logic [CW-1:0] r_ovh, r_pdly, r_plen, r_sdly, r_slen, r_rst, r_dsdly, r_dslen;
  logic          r_dsen;

  // configuration check on the raw inputs
  logic [XW-1:0] x_ovh, x_pd, x_pl, x_sd, x_sl, x_dd, x_dl;
  logic [XW-1:0] e_p, e_s, ov_lo, ov_hi, int_eff, wait_w;
  logic          bad;

  assign x_ovh = XW'(ovh_len);
  assign x_pd  = XW'(pre_dly);
  assign x_pl  = XW'(pre_len);
  assign x_sd  = XW'(smp_dly);
  assign x_sl  = XW'(smp_len);
  assign x_dd  = XW'(ds_dly);
  assign x_dl  = XW'(ds_len);
  assign e_p   = x_pd + x_pl;
  assign e_s   = x_sd + x_sl;
  assign ov_lo = (x_pd > x_sd) ? x_pd : x_sd;
  assign ov_hi = (e_p < e_s) ? e_p : e_s;
  assign int_eff = (XW'(int_len) < XW'(INT_MIN)) ? XW'(INT_MIN) : XW'(int_len);
  assign wait_w  = int_eff - x_sd;

  assign bad = (x_ovh < XW'(OVH_MIN)) || (x_ovh > XW'(OVH_MAX))
            || (x_pl < XW'(PRE_MIN))  || (x_pl > XW'(PRE_MAX))
            || (x_sl < XW'(SMP_MIN))  || (x_sl > XW'(SMP_MAX))
            || (e_p > x_ovh) || (e_s > x_ovh)
            || (x_ovh <= x_sd + XW'(GAP_MIN))
            || (ov_hi <= ov_lo + XW'(OVL_MIN))
            || (int_eff <= x_sd)
            || (rst_len == '0)
            || (ds_en && ((x_dl < XW'(DS_MIN)) || (x_dd + x_dl > wait_w)));

  logic accept, go, xstart;
  assign accept = trig && (ex_st == EX_IDLE) && (xf_st != XF_XFER);
  assign go     = ((ex_st == EX_INT) && (ex_cnt == r_wait - XW'(1))) || (ex_st == EX_WAIT);
  assign xstart = go && (xf_st == XF_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_st   <= EX_IDLE;
      xf_st   <= XF_IDLE;
      ex_cnt  <= '0;
      xf_cnt  <= '0;
      row     <= '0;
      col     <= '0;
      cfg_err <= 1'b0;
      r_wait  <= '0;
      r_ovh   <= '0;
      r_pdly  <= '0;
      r_plen  <= '0;
      r_sdly  <= '0;
      r_slen  <= '0;
      r_rst   <= '0;
      r_dsen  <= 1'b0;
      r_dsdly <= '0;
      r_dslen <= '0;
    end else begin
      case (ex_st)
        EX_IDLE: if (accept) begin
          cfg_err <= bad;
          if (!bad) begin
            ex_st   <= EX_RST;
            ex_cnt  <= '0;
            r_wait  <= wait_w;
            r_ovh   <= ovh_len;
            r_pdly  <= pre_dly;
            r_plen  <= pre_len;
            r_sdly  <= smp_dly;
            r_slen  <= smp_len;
            r_rst   <= rst_len;
            r_dsen  <= ds_en;
            r_dsdly <= ds_dly;
            r_dslen <= ds_len;
          end
        end
        EX_RST: if (ex_cnt == XW'(r_rst) - XW'(1)) begin
          ex_st  <= EX_INT;
          ex_cnt <= '0;
        end else ex_cnt <= ex_cnt + XW'(1);
        EX_INT: if (go) ex_st <= xstart ? EX_IDLE : EX_WAIT;
                else    ex_cnt <= ex_cnt + XW'(1);
        EX_WAIT: if (xstart) ex_st <= EX_IDLE;
        default: ex_st <= EX_IDLE;
      endcase

      case (xf_st)
        XF_IDLE: if (xstart) begin
          xf_st  <= XF_XFER;
          xf_cnt <= '0;
        end
        XF_XFER: if (xf_cnt == r_ovh - CW'(1)) begin
          xf_st <= XF_READ;
          row   <= '0;
          col   <= '0;
        end else xf_cnt <= xf_cnt + CW'(1);
        XF_READ: if (col == KW'(COLS)) begin
          col <= '0;
          if (row == RW'(ROWS - 1)) xf_st <= XF_DONE;
          else row <= row + RW'(1);
        end else col <= col + KW'(1);
        default: xf_st <= XF_IDLE;
      endcase
    end
  end

  logic in_xfer;
  assign in_xfer   = (xf_st == XF_XFER);
  assign boost_n   = !in_xfer;
  assign pchg      = in_xfer && (xf_cnt >= r_pdly) && (XW'(xf_cnt) < XW'(r_pdly) + XW'(r_plen));
  assign smpl      = in_xfer && (xf_cnt >= r_sdly) && (XW'(xf_cnt) < XW'(r_sdly) + XW'(r_slen));
  assign pd_rst    = (ex_st == EX_RST);
  assign ds_rst    = (ex_st == EX_INT) && r_dsen && (ex_cnt >= XW'(r_dsdly))
                   && (ex_cnt < XW'(r_dsdly) + XW'(r_dslen));
  assign line_sync = (xf_st == XF_READ) && (col == '0);
  assign pix_stb   = (xf_st == XF_READ) && (col != '0);
  assign row_idx   = row;
  assign col_idx   = pix_stb ? col - KW'(1) : '0;
  assign done      = (xf_st == XF_DONE);
  assign busy      = (ex_st != EX_IDLE) || (xf_st != XF_IDLE);

  assert_enclose_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pchg || smpl) |-> !boost_n);
  assert_reset_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_rst |-> boost_n);
  assert_ds_in_integ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rst |-> (boost_n && !pd_rst));
  assert_readout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync || pix_stb) |-> (boost_n && !(line_sync && pix_stb)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boost_n || pd_rst || done) |-> busy);
  assert_xfer_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_n) |-> $past(!line_sync && !pix_stb));
endmodule

// File: tb/test_gs_frame_seq.sv
module test_gs_frame_seq;
  localparam int CW = 16, ROWS = 3, COLS = 4;
  localparam int OVH_MIN = 10, OVH_MAX = 40, PRE_MIN = 3, PRE_MAX = 12;
  localparam int SMP_MIN = 5, SMP_MAX = 16, OVL_MIN = 2, GAP_MIN = 6;
  localparam int INT_MIN = 8, DS_MIN = 3;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int KW = $clog2(COLS + 1);

  logic clk = 0, rst_n = 0, trig = 0, ds_en = 0;
  logic [CW-1:0] ovh_len = 0, pre_dly = 0, pre_len = 0, smp_dly = 0, smp_len = 0;
  logic [CW-1:0] int_len = 0, rst_len = 0, ds_dly = 0, ds_len = 0;
  logic boost_n, pchg, smpl, pd_rst, ds_rst, line_sync, pix_stb, done, busy, cfg_err;
  logic [RW-1:0] row_idx;
  logic [KW-1:0] col_idx;

  gs_frame_seq #(.CW(CW), .ROWS(ROWS), .COLS(COLS), .OVH_MIN(OVH_MIN), .OVH_MAX(OVH_MAX),
    .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX), .SMP_MIN(SMP_MIN), .SMP_MAX(SMP_MAX),
    .OVL_MIN(OVL_MIN), .GAP_MIN(GAP_MIN), .INT_MIN(INT_MIN), .DS_MIN(DS_MIN)) i_gs_frame_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ovh_len(ovh_len), .pre_dly(pre_dly),
    .pre_len(pre_len), .smp_dly(smp_dly), .smp_len(smp_len), .int_len(int_len),
    .rst_len(rst_len), .ds_en(ds_en), .ds_dly(ds_dly), .ds_len(ds_len), .boost_n(boost_n),
    .pchg(pchg), .smpl(smpl), .pd_rst(pd_rst), .ds_rst(ds_rst), .line_sync(line_sync),
    .pix_stb(pix_stb), .row_idx(row_idx), .col_idx(col_idx), .done(done), .busy(busy),
    .cfg_err(cfg_err));

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int t_trig, t_bfall, t_brise, t_prise, t_pfall, t_srise, t_sfall, t_rrise, t_rfall;
  int t_drise, t_dfall, t_done, n_bfall, n_rrise, n_sync, n_pix, n_done, ds_cnt, idx_err, exp_col;
  logic pb = 1, pp = 0, ps = 0, pr = 0, pd = 0, ptrig = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    {t_trig, t_bfall, t_brise, t_prise, t_pfall, t_srise, t_sfall} = {7{-1}};
    {t_rrise, t_rfall, t_drise, t_dfall, t_done} = {5{-1}};
    {n_bfall, n_rrise, n_sync, n_pix, n_done, ds_cnt, idx_err, exp_col} = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (trig && !ptrig) t_trig = cyc;
      if (!boost_n && pb) begin t_bfall = cyc; n_bfall++; end
      if (boost_n && !pb) t_brise = cyc;
      if (pchg && !pp) t_prise = cyc;
      if (!pchg && pp) t_pfall = cyc;
      if (smpl && !ps) t_srise = cyc;
      if (!smpl && ps) t_sfall = cyc;
      if (pd_rst && !pr) begin t_rrise = cyc; n_rrise++; end
      if (!pd_rst && pr) t_rfall = cyc;
      if (ds_rst && !pd) t_drise = cyc;
      if (!ds_rst && pd) t_dfall = cyc;
      if (ds_rst) ds_cnt++;
      if (line_sync) begin
        if (int'(row_idx) != n_sync % ROWS) idx_err++;
        n_sync++;
        exp_col = 0;
      end
      if (pix_stb) begin
        if (int'(col_idx) != exp_col || int'(row_idx) != (n_sync - 1) % ROWS) idx_err++;
        exp_col++;
        n_pix++;
      end
      if (done) begin n_done++; t_done = cyc; end
    end
    pb = boost_n; pp = pchg; ps = smpl; pr = pd_rst; pd = ds_rst; ptrig = trig;
  end

  task automatic fin();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    fin();
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done(input int k);
    for (int g = 0; g < 5000 && n_done < k; g++) step(1);
  endtask

  function automatic int ieff(input int il);
    return (il < INT_MIN) ? INT_MIN : il;
  endfunction

  function automatic bit cfg_ok(input int o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    int lo, hi;
    lo = (pdl > sd) ? pdl : sd;
    hi = (pdl + pl < sd + sl) ? pdl + pl : sd + sl;
    if (o < OVH_MIN || o > OVH_MAX || pl < PRE_MIN || pl > PRE_MAX) return 0;
    if (sl < SMP_MIN || sl > SMP_MAX) return 0;
    if (pdl + pl > o || sd + sl > o || o - sd <= GAP_MIN) return 0;
    if (hi - lo <= OVL_MIN) return 0;
    if (ieff(il) <= sd || rl < 1) return 0;
    if (de != 0 && (dl < DS_MIN || dd + dl > ieff(il) - sd)) return 0;
    return 1;
  endfunction

  task automatic drive(input int o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    ovh_len = CW'(o); pre_dly = CW'(pdl); pre_len = CW'(pl); smp_dly = CW'(sd);
    smp_len = CW'(sl); int_len = CW'(il); rst_len = CW'(rl); ds_en = (de != 0);
    ds_dly = CW'(dd); ds_len = CW'(dl);
  endtask

  task automatic pulse();
    trig = 1; step(1); trig = 0;
  endtask

  task automatic run_valid(input int o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    clr();
    drive(o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    pulse();
    chk(busy == 1, "R9 busy after trigger", busy, 1);
    wait_done(1);
    chk(cfg_err == 0, "R12 cfg_err cleared", cfg_err, 0);
    chk(t_rrise == t_trig + 1, "R6 reset start", t_rrise - t_trig, 1);
    chk(t_rfall - t_rrise == rl, "R6 reset width", t_rfall - t_rrise, rl);
    chk(t_brise - t_bfall == o, "R2 boost low length", t_brise - t_bfall, o);
    chk(t_prise - t_bfall == pdl && t_pfall - t_prise == pl, "R3 precharge",
        t_prise - t_bfall, pdl);
    chk(t_srise - t_bfall == sd && t_sfall - t_srise == sl, "R3 sample",
        t_sfall - t_srise, sl);
    chk(t_srise - t_rfall == ieff(il), "R5 integration", t_srise - t_rfall, ieff(il));
    if (de != 0)
      chk(t_drise - t_rfall == dd && t_dfall - t_drise == dl, "R7 double-slope pulse",
          t_drise - t_rfall, dd);
    else
      chk(ds_cnt == 0, "R7 double-slope off", ds_cnt, 0);
    chk(n_sync == ROWS && n_pix == ROWS * COLS && idx_err == 0, "R8 readout",
        n_pix, ROWS * COLS);
    chk(t_done - t_brise == ROWS * (COLS + 1), "R9 done timing", t_done - t_brise,
        ROWS * (COLS + 1));
    chk(busy == 0 && n_done == 1, "R9 busy released", busy, 0);
  endtask

  task automatic run_bad(input int o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    clr();
    drive(o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    pulse();
    step(6);
    chk(cfg_err == 1 && busy == 0 && n_bfall == 0 && n_rrise == 0, "R4 rejected config",
        cfg_err, 1);
  endtask

  task automatic run_any(input int o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    if (cfg_ok(o, pdl, pl, sd, sl, il, rl, de, dd, dl)) run_valid(o, pdl, pl, sd, sl, il, rl, de, dd, dl);
    else run_bad(o, pdl, pl, sd, sl, il, rl, de, dd, dl);
  endtask

  function automatic int ur(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  initial begin
    int a0, a1, a2, a3, a4, a5, a6, a7, a8, a9, tda;
    void'($urandom(32'd20240611));
    clr();
    step(3);
    chk(boost_n == 1 && !pchg && !smpl && !pd_rst && !ds_rst && !busy && !done && !cfg_err,
        "R1 state in reset", boost_n, 1);
    rst_n = 1;
    step(2);
    chk(boost_n == 1 && !line_sync && !pix_stb && !busy && !cfg_err, "R1 state after reset",
        busy, 0);

    run_valid(20, 2, 8, 4, 10, 20, 2, 1, 3, 4);
    run_valid(20, 2, 8, 4, 10, 2, 1, 0, 0, 0);      // R5 clamped to minimum
    run_valid(OVH_MIN, 0, 5, 1, 5, INT_MIN, 1, 0, 0, 0);
    run_valid(OVH_MAX, 2, 12, 4, 16, 30, 3, 1, 12, 14);
    run_valid(20, 8, 10, 13, 6, 20, 2, 0, 0, 0);    // R4 gap one above limit
    run_bad(20, 8, 10, 14, 6, 20, 2, 0, 0, 0);      // R4 gap at limit
    run_valid(20, 2, 8, 4, 10, 20, 2, 0, 0, 0);     // R12 clears error
    run_bad(20, 2, 4, 4, 10, 20, 2, 0, 0, 0);       // R4 overlap equal to limit
    run_valid(20, 2, 5, 4, 10, 20, 2, 0, 0, 0);
    run_bad(20, 2, 12, 8, 10, 8, 2, 0, 0, 0);       // R4 integration not above sample offset
    run_valid(20, 2, 12, 8, 10, 9, 2, 0, 0, 0);
    run_valid(20, 2, 8, 4, 10, 20, 2, 1, 12, 4);    // R7 pulse ends at transfer
    run_bad(20, 2, 8, 4, 10, 20, 2, 1, 13, 4);
    run_bad(20, 2, 8, 4, 10, 20, 2, 1, 3, 2);       // R4 double-slope too short
    run_bad(20, 2, 8, 4, 10, 20, 0, 0, 0, 0);       // R4 zero reset width
    run_bad(OVH_MAX + 1, 2, 8, 4, 10, 20, 2, 0, 0, 0);

    for (int k = 0; k < 10; k++) begin
      for (int g = 0; g < 500; g++) begin
        a0 = ur(OVH_MIN, OVH_MAX); a1 = ur(0, 10); a2 = ur(PRE_MIN, PRE_MAX);
        a3 = ur(0, 12); a4 = ur(SMP_MIN, SMP_MAX); a5 = ur(0, 30); a6 = ur(1, 4);
        a7 = ur(0, 1); a8 = ur(0, 6); a9 = ur(DS_MIN, 6);
        if (cfg_ok(a0, a1, a2, a3, a4, a5, a6, a7, a8, a9)) break;
      end
      run_any(a0, a1, a2, a3, a4, a5, a6, a7, a8, a9);
    end
    for (int k = 0; k < 12; k++)
      run_any(ur(6, 44), ur(0, 10), ur(2, 13), ur(0, 12), ur(4, 17), ur(0, 30), ur(0, 4),
              ur(0, 1), ur(0, 6), ur(2, 6));

    // R10: trigger during readout
    clr();
    drive(20, 2, 8, 4, 10, 20, 2, 0, 0, 0);
    pulse();
    for (int g = 0; g < 2000 && n_sync < 1; g++) step(1);
    drive(20, 2, 8, 4, 10, 8, 2, 0, 0, 0);
    pulse();
    wait_done(1);
    tda = t_done;
    chk(n_rrise == 2 && t_rrise < tda, "R10 reset during readout", n_rrise, 2);
    wait_done(2);
    chk(t_bfall > tda, "R10 transfer after done", t_bfall - tda, 1);
    chk(t_srise - t_rfall > ieff(8), "R10 integration extended", t_srise - t_rfall, ieff(8) + 1);
    step(1);
    chk(busy == 0 && n_done == 2, "R9 busy after overlapped frames", busy, 0);

    // R11: triggers during integration and transfer are ignored
    clr();
    drive(20, 2, 8, 4, 10, 20, 2, 0, 0, 0);
    pulse();
    for (int g = 0; g < 2000 && t_rfall < 0; g++) step(1);
    pulse();
    for (int g = 0; g < 2000 && n_bfall < 1; g++) step(1);
    pulse();
    wait_done(1);
    step(20);
    chk(n_rrise == 1 && n_done == 1 && busy == 0, "R11 triggers ignored", n_rrise, 1);

    fin();
  end
endmodule